// File: doc/BRIEF.md
# Board-Test Pad Mode Controller

This block sits between the core logic and the pad ring. It decides whether the chip works normally or in one of several board-level test modes, and it drives the output-enable and output value of every output pad to suit that mode. A dedicated test-enable input takes four multipurpose pins away from their ordinary use. While test-enable is high, those four pins are read as a one-hot select code. The code picks one of four modes: every output tristated, every output driven high, every output driven low, or a chain of two-input NAND gates that runs through all input pads and ends on one output-only pad.

The whole block is combinational. A tester can enter, change or leave a test mode by changing pin levels alone, with no clock running. The number of input pads, the number of output pads and the index of the pad that carries the chain result are parameters.

Top module: `boardtest_pinmux`

## Requirements
- R1: With testEnable low, every output pad follows the core: padOut equals coreOut and padOe equals coreOe, bit for bit.
- R2: With testEnable low, sharedFuncIn equals sharedPinIn. With testEnable high, sharedFuncIn is all zeros, so the ordinary function of the four shared pins sees no activity.
- R3: Mode selection is purely combinational. A change on testEnable or sharedPinIn reaches padOut and padOe with no clock edge.
- R4: With testEnable high and select code 4'b0001 (float), every padOe bit is 0 and every padOut bit is 0.
- R5: With testEnable high and select code 4'b0100 (drive high), every padOe bit is 1 and every padOut bit is 1.
- R6: With testEnable high and select code 4'b1000 (drive low), every padOe bit is 1 and every padOut bit is 0.
- R7: With testEnable high and select code 4'b0010 (NAND chain), pad CHAIN_PIN is enabled and carries the chain result. Stage 0 is NAND(1, padIn[0]), and stage k is NAND(stage k-1, padIn[k]). The result is the last stage, so the chain is N_IN gates long.
- R8: In NAND-chain mode, every output pad other than CHAIN_PIN has padOe 0 and padOut 0.
- R9: With testEnable high and any select code other than the four above (including 4'b0000 and codes with several bits set), every pad has padOe 0 and padOut 0.
- R10: While testEnable is high, coreOut and coreOe have no effect on padOut or padOe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| testEnable | input | 1 | Dedicated board-test enable; high selects test operation |
| sharedPinIn | input | 4 | Levels on the four multipurpose pins; one-hot test-select code when testEnable is high |
| sharedFuncIn | output | 4 | Shared-pin levels passed on to their ordinary function; zero during test |
| padIn | input | N_IN | Input-path levels of all input and bidirectional pads, in chain order |
| coreOut | input | N_OUT | Output values from the core for normal operation |
| coreOe | input | N_OUT | Output enables from the core for normal operation |
| padOut | output | N_OUT | Value driven to each output pad |
| padOe | output | N_OUT | Driver enable for each output pad; 0 means tristated |

## Verification
The bench walks a single low input through every position of the NAND chain, starting from all-ones and from all-zeros backgrounds. A chain that skips a pad, reverses the order or drops the constant-one start would give the wrong parity of inversions, and the result pad would show it. It drives select codes with no bit set and with several bits set, where a priority decoder would wrongly land in a drive mode. It also drives random core values during every test mode, which catches any leak of normal data onto the pads. Finally, it changes the mode between clock edges and checks the outputs before the next edge, which would expose a mode held in a register.

// File: rtl/boardtest_pkg.sv
package boardtest_pkg;

  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] CODE_FLOAT = 4'b0001;
  localparam logic [SEL_W-1:0] CODE_CHAIN = 4'b0010;
  localparam logic [SEL_W-1:0] CODE_HIGH  = 4'b0100;
  localparam logic [SEL_W-1:0] CODE_LOW   = 4'b1000;

  typedef enum logic [2:0] {
    MODE_NORMAL,
    MODE_FLOAT,
    MODE_CHAIN,
    MODE_HIGH,
    MODE_LOW,
    MODE_BADCODE
  } modeT;

  // strobes from control to the pad datapath
  typedef struct packed {
    logic passCore;   // normal operation, follow the core
    logic forceAll;   // every driver enabled with forceVal
    logic forceVal;   // level used when forceAll is set
    logic chainOn;    // chain result on the chain pad, rest quiet
  } padStrobeT;

endpackage

// File: rtl/boardtest_ctrl.sv
module boardtest_ctrl
  import boardtest_pkg::*;
(
  input  logic             testEnable,
  input  logic [SEL_W-1:0] sharedPinIn,
  output logic [SEL_W-1:0] sharedFuncIn,
  output padStrobeT        strobe
);

  modeT mode;

  always_comb begin
    if (!testEnable) begin
      mode = MODE_NORMAL;
    end else begin
      unique case (sharedPinIn)
        CODE_FLOAT: mode = MODE_FLOAT;
        CODE_CHAIN: mode = MODE_CHAIN;
        CODE_HIGH:  mode = MODE_HIGH;
        CODE_LOW:   mode = MODE_LOW;
        default:    mode = MODE_BADCODE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_NORMAL: strobe.passCore = 1'b1;
      MODE_CHAIN:  strobe.chainOn  = 1'b1;
      MODE_HIGH: begin
        strobe.forceAll = 1'b1;
        strobe.forceVal = 1'b1;
      end
      MODE_LOW:    strobe.forceAll = 1'b1;
      default:     strobe = '0;
    endcase
  end

  // the ordinary function of the shared pins sees nothing during test
  assign sharedFuncIn = testEnable ? '0 : sharedPinIn;

endmodule

// File: rtl/boardtest_datapath.sv
module boardtest_datapath
  import boardtest_pkg::*;
#(
  parameter int N_IN      = 16,
  parameter int N_OUT     = 12,
  parameter int CHAIN_PIN = 3
) (
  input  padStrobeT        strobe,
  input  logic [N_IN-1:0]  padIn,
  input  logic [N_OUT-1:0] coreOut,
  input  logic [N_OUT-1:0] coreOe,
  output logic [N_OUT-1:0] padOut,
  output logic [N_OUT-1:0] padOe
);

  localparam int LAST = N_IN - 1;

  logic [N_IN-1:0] link;
  logic            chainBit;

  // two-input NAND chain through every input pad
  generate
    for (genvar k = 0; k < N_IN; k++) begin : g_link
      if (k == 0) begin : g_head
        assign link[k] = ~(1'b1 & padIn[k]);
      end else begin : g_body
        assign link[k] = ~(link[k-1] & padIn[k]);
      end
    end
  endgenerate

  assign chainBit = link[LAST];

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_pad
      if (i == CHAIN_PIN) begin : g_chainPad
        always_comb begin
          if (strobe.passCore) begin
            padOut[i] = coreOut[i];
            padOe[i]  = coreOe[i];
          end else if (strobe.forceAll) begin
            padOut[i] = strobe.forceVal;
            padOe[i]  = 1'b1;
          end else if (strobe.chainOn) begin
            padOut[i] = chainBit;
            padOe[i]  = 1'b1;
          end else begin
            padOut[i] = 1'b0;
            padOe[i]  = 1'b0;
          end
        end
      end else begin : g_plainPad
        always_comb begin
          if (strobe.passCore) begin
            padOut[i] = coreOut[i];
            padOe[i]  = coreOe[i];
          end else if (strobe.forceAll) begin
            padOut[i] = strobe.forceVal;
            padOe[i]  = 1'b1;
          end else begin
            padOut[i] = 1'b0;
            padOe[i]  = 1'b0;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/boardtest_pinmux.sv
module boardtest_pinmux
  import boardtest_pkg::*;
#(
  parameter int N_IN      = 16,
  parameter int N_OUT     = 12,
  parameter int CHAIN_PIN = 3
) (
  input  logic             testEnable,
  input  logic [3:0]       sharedPinIn,
  output logic [3:0]       sharedFuncIn,
  input  logic [N_IN-1:0]  padIn,
  input  logic [N_OUT-1:0] coreOut,
  input  logic [N_OUT-1:0] coreOe,
  output logic [N_OUT-1:0] padOut,
  output logic [N_OUT-1:0] padOe
);

  padStrobeT strobe;

  boardtest_ctrl u_ctrl (
    .testEnable  (testEnable),
    .sharedPinIn (sharedPinIn),
    .sharedFuncIn(sharedFuncIn),
    .strobe      (strobe)
  );

  boardtest_datapath #(
    .N_IN     (N_IN),
    .N_OUT    (N_OUT),
    .CHAIN_PIN(CHAIN_PIN)
  ) u_dp (
    .strobe (strobe),
    .padIn  (padIn),
    .coreOut(coreOut),
    .coreOe (coreOe),
    .padOut (padOut),
    .padOe  (padOe)
  );

endmodule

// File: rtl/boardtest_pinmux_chk.sv
module boardtest_pinmux_chk #(
  parameter int N_IN      = 16,
  parameter int N_OUT     = 12,
  parameter int CHAIN_PIN = 3
) (
  input logic             testEnable,
  input logic [3:0]       sharedPinIn,
  input logic [3:0]       sharedFuncIn,
  input logic [N_IN-1:0]  padIn,
  input logic [N_OUT-1:0] coreOut,
  input logic [N_OUT-1:0] coreOe,
  input logic [N_OUT-1:0] padOut,
  input logic [N_OUT-1:0] padOe
);

  logic known;
  logic inFloat, inChain, inHigh, inLow, inBad;
  logic [N_OUT-1:0] others;

  assign known   = !$isunknown({testEnable, sharedPinIn, sharedFuncIn, padIn,
                                coreOut, coreOe, padOut, padOe});
  assign inFloat = testEnable && (sharedPinIn == 4'b0001);
  assign inChain = testEnable && (sharedPinIn == 4'b0010);
  assign inHigh  = testEnable && (sharedPinIn == 4'b0100);
  assign inLow   = testEnable && (sharedPinIn == 4'b1000);
  assign inBad   = testEnable && ($countones(sharedPinIn) != 1);

  always_comb begin
    others = {N_OUT{1'b1}};
    others[CHAIN_PIN] = 1'b0;
  end

  always_comb begin
    if (known) begin
      // R1
      normal_pass_chk: assert (testEnable || (padOut == coreOut && padOe == coreOe))
        else $error("normal_pass_chk");
      // R2
      shared_quiet_chk: assert (!testEnable || sharedFuncIn == 4'b0000)
        else $error("shared_quiet_chk");
      // R4
      float_off_chk: assert (!inFloat || (padOe == '0 && padOut == '0))
        else $error("float_off_chk");
      // R5
      drive_high_chk: assert (!inHigh || (&padOe && &padOut))
        else $error("drive_high_chk");
      // R6
      drive_low_chk: assert (!inLow || (&padOe && padOut == '0))
        else $error("drive_low_chk");
      // R8
      chain_quiet_chk: assert (!inChain || ($countones(padOe) == 1 && padOe[CHAIN_PIN]
                                             && (padOut & others) == '0))
        else $error("chain_quiet_chk");
      // R9
      bad_code_chk: assert (!inBad || (padOe == '0 && padOut == '0))
        else $error("bad_code_chk");
    end
  end

endmodule

bind boardtest_pinmux boardtest_pinmux_chk #(
  .N_IN     (N_IN),
  .N_OUT    (N_OUT),
  .CHAIN_PIN(CHAIN_PIN)
) u_chk (
  .testEnable  (testEnable),
  .sharedPinIn (sharedPinIn),
  .sharedFuncIn(sharedFuncIn),
  .padIn       (padIn),
  .coreOut     (coreOut),
  .coreOe      (coreOe),
  .padOut      (padOut),
  .padOe       (padOe)
);

// File: tb/tb_boardtest_pinmux.sv
`timescale 1ns/1ps
module tb_boardtest_pinmux;

  localparam int NI = 16;
  localparam int NO = 12;
  localparam int CP = 3;

  logic          clk = 1'b0;
  logic          testEnable;
  logic [3:0]    sharedPinIn;
  logic [3:0]    sharedFuncIn;
  logic [NI-1:0] padIn;
  logic [NO-1:0] coreOut, coreOe, padOut, padOe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  boardtest_pinmux #(.N_IN(NI), .N_OUT(NO), .CHAIN_PIN(CP)) dut (
    .testEnable  (testEnable),
    .sharedPinIn (sharedPinIn),
    .sharedFuncIn(sharedFuncIn),
    .padIn       (padIn),
    .coreOut     (coreOut),
    .coreOe      (coreOe),
    .padOut      (padOut),
    .padOe       (padOe)
  );

  // behavioural reference
  function automatic int refChain(input logic [NI-1:0] v);
    int acc = 1;
    for (int k = 0; k < NI; k++) acc = (acc == 1 && v[k] == 1'b1) ? 0 : 1;
    return acc;
  endfunction

  task automatic compare(input string req);
    logic [NO-1:0] eOut, eOe;
    logic [3:0]    eShared;
    eShared = testEnable ? 4'b0000 : sharedPinIn;
    if (!testEnable) begin
      eOut = coreOut; eOe = coreOe;
    end else if (sharedPinIn == 4'b0100) begin
      eOut = '1; eOe = '1;
    end else if (sharedPinIn == 4'b1000) begin
      eOut = '0; eOe = '1;
    end else if (sharedPinIn == 4'b0010) begin
      eOut = '0; eOe = '0;
      eOe[CP] = 1'b1;
      eOut[CP] = (refChain(padIn) == 1);
    end else begin
      eOut = '0; eOe = '0;
    end
    total++;
    if (padOut !== eOut || padOe !== eOe || sharedFuncIn !== eShared) begin
      bad++;
      $display("FAIL %s: out=%h oe=%h sh=%h expected out=%h oe=%h sh=%h",
               req, padOut, padOe, sharedFuncIn, eOut, eOe, eShared);
    end
  endtask

  // drive on the falling edge, compare on the next rising edge
  task automatic apply(input logic te, input logic [3:0] code,
                       input logic [NI-1:0] pin, input string req);
    @(negedge clk);
    testEnable  = te;
    sharedPinIn = code;
    padIn       = pin;
    coreOut     = NO'($urandom);
    coreOe      = NO'($urandom);
    @(posedge clk);
    #1 compare(req);
  endtask

  initial begin
    testEnable = 0; sharedPinIn = 0; padIn = 0; coreOut = 0; coreOe = 0;
    @(posedge clk);
    #1 compare("R1 idle");

    for (int n = 0; n < 20; n++)
      apply(1'b0, 4'($urandom), NI'($urandom), "R1 R2 normal");

    for (int n = 0; n < 8; n++) begin
      apply(1'b1, 4'b0001, NI'($urandom), "R4 R10 float");
      apply(1'b1, 4'b0100, NI'($urandom), "R5 R10 high");
      apply(1'b1, 4'b1000, NI'($urandom), "R6 R10 low");
    end

    apply(1'b1, 4'b0010, '1, "R7 all ones");
    apply(1'b1, 4'b0010, '0, "R7 all zeros");
    for (int k = 0; k < NI; k++) begin
      logic [NI-1:0] v;
      v = '1; v[k] = 1'b0;
      apply(1'b1, 4'b0010, v, "R7 R8 walk zero");
      v = '0; v[k] = 1'b1;
      apply(1'b1, 4'b0010, v, "R7 R8 walk one");
    end
    for (int n = 0; n < 20; n++)
      apply(1'b1, 4'b0010, NI'($urandom), "R7 R8 random");

    apply(1'b1, 4'b0000, NI'($urandom), "R9 no bit");
    apply(1'b1, 4'b0011, NI'($urandom), "R9 two bits");
    apply(1'b1, 4'b1100, NI'($urandom), "R9 two bits");
    apply(1'b1, 4'b1111, NI'($urandom), "R9 all bits");
    apply(1'b1, 4'b0110, NI'($urandom), "R9 two bits");

    // R3: changes between edges show up with no clock edge
    @(posedge clk);
    #3 testEnable = 1; sharedPinIn = 4'b0100;
    #1 compare("R3 enter high");
    #2 sharedPinIn = 4'b1000;
    #1 compare("R3 to low");
    #2 testEnable = 0;
    #1 compare("R3 leave");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule